// File: doc/BRIEF.md
# Element-Frame Memory-to-Memory DMA Channel

This block is a single DMA channel that copies one block of data from a source region to a destination region of memory. A block is a programmed number of frames, and each frame is a programmed number of elements of 8, 16 or 32 bits. Software sets up the channel through a small word-addressed register port, starts it with an enable bit, and learns of completion from a block-done status bit or from an interrupt line. On the memory side the channel is a plain valid/ready master. Each element is one read beat followed by one write beat.

Source and destination addresses are handled separately. Each one is either held constant or advanced after every element by an element step, and the last element of a frame adds a frame adjustment on top. Software can read back the live addresses and the element and frame positions. A soft-reset request clears the channel, and a status bit reports when that reset has finished.

Top module: `dma_chan_eng`

Register word addresses on `cfg_addr`:
- 0: control
- 1: element count
- 2: frame count
- 3: source base
- 4: destination base
- 5: element size
- 6: source element index
- 7: destination element index
- 8: source frame index
- 9: destination frame index
- 10: block interrupt enable
- 11: block status
- 12: current source address
- 13: current destination address
- 14: current element
- 15: current frame
- 16: interrupt status
- 17: interrupt enable
- 18: soft-reset request
- 19: soft-reset status

## Requirements
- R1: After `rst_n` low, every configuration, position and status register reads 0, soft-reset status (word 19) bit 0 reads 1, and `irq_o` is low.
- R2: Word 5 bits [1:0] select the element size as log2 of the byte width: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes, and 3 behaves as 2. The value appears on `m_size`, and exactly that many bytes are moved per element.
- R3: Control bits [13:12] give the source mode and bits [15:14] the destination mode. Value 1 is post-increment. Every other value is constant mode, in which the address never changes.
- R4: In post-increment mode, a non-final element of a frame advances the address by size×element_index. The last element of a frame advances it by size×(element_index + frame_index − 1). Index value 1 on both therefore gives contiguous stepping. Indices are unsigned in the default configuration.
- R5: A block with E elements and F frames makes exactly E×F read beats and E×F write beats, each read followed by its write. With `m_ready` held high, control bit 7 reads 1 for exactly 2×E×F cycles after the start write.
- R6: While a beat is presented and `m_ready` is low, `m_valid`, `m_write` and `m_addr` are held unchanged.
- R7: A control write with bit 7 set while idle starts the block. Bit 7 reads 1 while the block runs and clears itself when it completes.
- R8: If E or F is zero, a start makes no memory access and completes at once.
- R9: Words 12 to 15 return the live source address, destination address, element position and frame position. After completion the element position is 0 and the frame position is F (0 when the block was empty).
- R10: Block status bit 5 sets on completion. Writing 1 to it clears it, and writing 0 has no effect.
- R11: When block interrupt enable bit 5 is set, completion also sets interrupt status bit 0, which is cleared by writing 1. `irq_o` equals interrupt status bit 0 ANDed with interrupt enable bit 0.
- R12: Writing 1 to soft-reset request bit 1 aborts any transfer, clears all channel, status and enable registers, and drives soft-reset status bit 0 low for RST_CYCLES cycles before it reads 1 again. Register writes during that time are ignored.
- R13: While a block runs, writes to words 0 to 10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from `cfg_addr`) |
| m_valid | output | 1 | Memory beat request |
| m_write | output | 1 | 1 = write beat, 0 = read beat |
| m_size | output | 2 | log2 of element byte width |
| m_addr | output | ADDR_W | Byte address of the beat |
| m_wdata | output | 32 | Write data, element in the low bytes |
| m_ready | input | 1 | Beat accepted this cycle |
| m_rdata | input | 32 | Read data, element in the low bytes, valid with `m_ready` |
| irq_o | output | 1 | Block-complete interrupt |

## Verification
A register write takes effect at the clock edge where `cfg_we` is sampled, so its readback is due on the next falling edge. The first read beat appears in the cycle after the start edge. Without stalls each element takes two cycles, so the enable bit is seen high on exactly 2×E×F falling-edge samples. Status, position readback and `irq_o` are due right after the edge that accepts the final write beat, and the soft-reset done bit is due RST_CYCLES samples after the request. The bench drives and samples only on falling edges and counts those samples against these figures. It sweeps element size, both address modes, counts including zero, and both index values, with and without memory stalls, and predicts every destination byte from the stepping formula.

// File: rtl/dma_pkg.sv
package dma_pkg;
   localparam int REG_AW = 5;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } xfer_st_e;

   localparam logic [1:0] MODE_POST = 2'd1;

   localparam logic [REG_AW-1:0] A_CTRL  = 5'd0;
   localparam logic [REG_AW-1:0] A_NELEM = 5'd1;
   localparam logic [REG_AW-1:0] A_NFRM  = 5'd2;
   localparam logic [REG_AW-1:0] A_SBASE = 5'd3;
   localparam logic [REG_AW-1:0] A_DBASE = 5'd4;
   localparam logic [REG_AW-1:0] A_DTYPE = 5'd5;
   localparam logic [REG_AW-1:0] A_SEIDX = 5'd6;
   localparam logic [REG_AW-1:0] A_DEIDX = 5'd7;
   localparam logic [REG_AW-1:0] A_SFIDX = 5'd8;
   localparam logic [REG_AW-1:0] A_DFIDX = 5'd9;
   localparam logic [REG_AW-1:0] A_BIE   = 5'd10;
   localparam logic [REG_AW-1:0] A_BSTAT = 5'd11;
   localparam logic [REG_AW-1:0] A_CSRC  = 5'd12;
   localparam logic [REG_AW-1:0] A_CDST  = 5'd13;
   localparam logic [REG_AW-1:0] A_CELEM = 5'd14;
   localparam logic [REG_AW-1:0] A_CFRM  = 5'd15;
   localparam logic [REG_AW-1:0] A_ISTAT = 5'd16;
   localparam logic [REG_AW-1:0] A_IEN   = 5'd17;
   localparam logic [REG_AW-1:0] A_SRREQ = 5'd18;
   localparam logic [REG_AW-1:0] A_SRSTS = 5'd19;
endpackage

// File: rtl/dma_step.sv
module dma_step #(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 16,
   parameter bit SIGNED_IDX = 1'b0
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic              inc,
   input  logic [1:0]        dtype,
   input  logic [IDX_W-1:0]  eidx,
   input  logic [IDX_W-1:0]  fidx,
   input  logic              frame_end,
   output logic [ADDR_W-1:0] nxt
);
   logic [ADDR_W-1:0] e_ext, f_ext, units;

   if (SIGNED_IDX) begin : g_sext
      assign e_ext = ADDR_W'($signed(eidx));
      assign f_ext = ADDR_W'($signed(fidx));
   end else begin : g_zext
      assign e_ext = ADDR_W'(eidx);
      assign f_ext = ADDR_W'(fidx);
   end

   assign units = e_ext + (frame_end ? (f_ext - ADDR_W'(1)) : '0);
   assign nxt   = inc ? (cur + (units << dtype)) : cur;
endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl
   import dma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter int IDX_W      = 16,
   parameter bit SIGNED_IDX = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              start,
   input  logic [1:0]        dtype,
   input  logic [1:0]        src_mode,
   input  logic [1:0]        dst_mode,
   input  logic [CNT_W-1:0]  n_elem,
   input  logic [CNT_W-1:0]  n_frame,
   input  logic [ADDR_W-1:0] src_base,
   input  logic [ADDR_W-1:0] dst_base,
   input  logic [IDX_W-1:0]  src_eidx,
   input  logic [IDX_W-1:0]  src_fidx,
   input  logic [IDX_W-1:0]  dst_eidx,
   input  logic [IDX_W-1:0]  dst_fidx,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              mem_valid,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [ADDR_W-1:0] cur_src,
   output logic [ADDR_W-1:0] cur_dst,
   output logic [CNT_W-1:0]  cur_elem,
   output logic [CNT_W-1:0]  cur_frame
);
   xfer_st_e          st_q;
   logic [DATA_W-1:0] hold_q;
   logic              empty, last_elem, last_frame, wr_fire;
   logic [ADDR_W-1:0] src_nxt, dst_nxt;

   assign empty      = (n_elem == '0) || (n_frame == '0);
   assign last_elem  = cur_elem  == (n_elem  - CNT_W'(1));
   assign last_frame = cur_frame == (n_frame - CNT_W'(1));
   assign wr_fire    = (st_q == ST_WR) && mem_ready;

   assign busy      = st_q != ST_IDLE;
   assign mem_valid = st_q != ST_IDLE;
   assign mem_we    = st_q == ST_WR;
   assign mem_addr  = (st_q == ST_WR) ? cur_dst : cur_src;
   assign mem_wdata = hold_q;
   assign done      = (start && empty) || (wr_fire && last_elem && last_frame);

   dma_step #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SIGNED_IDX(SIGNED_IDX)) u_src_step (
      .cur(cur_src), .inc(src_mode == MODE_POST), .dtype(dtype),
      .eidx(src_eidx), .fidx(src_fidx), .frame_end(last_elem), .nxt(src_nxt)
   );

   dma_step #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SIGNED_IDX(SIGNED_IDX)) u_dst_step (
      .cur(cur_dst), .inc(dst_mode == MODE_POST), .dtype(dtype),
      .eidx(dst_eidx), .fidx(dst_fidx), .frame_end(last_elem), .nxt(dst_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         hold_q    <= '0;
         cur_src   <= '0;
         cur_dst   <= '0;
         cur_elem  <= '0;
         cur_frame <= '0;
      end else if (clr) begin
         st_q      <= ST_IDLE;
         hold_q    <= '0;
         cur_src   <= '0;
         cur_dst   <= '0;
         cur_elem  <= '0;
         cur_frame <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start) begin
               cur_src   <= src_base;
               cur_dst   <= dst_base;
               cur_elem  <= '0;
               cur_frame <= '0;
               st_q      <= empty ? ST_IDLE : ST_RD;
            end
            ST_RD: if (mem_ready) begin
               hold_q <= mem_rdata;
               st_q   <= ST_WR;
            end
            ST_WR: if (mem_ready) begin
               cur_src <= src_nxt;
               cur_dst <= dst_nxt;
               if (last_elem) begin
                  cur_elem  <= '0;
                  cur_frame <= cur_frame + CNT_W'(1);
               end else begin
                  cur_elem <= cur_elem + CNT_W'(1);
               end
               st_q <= (last_elem && last_frame) ? ST_IDLE : ST_RD;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dma_chan_eng.sv
module dma_chan_eng
   import dma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int IDX_W      = 16,
   parameter int RST_CYCLES = 8,
   parameter bit SIGNED_IDX = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [4:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              m_valid,
   output logic              m_write,
   output logic [1:0]        m_size,
   output logic [ADDR_W-1:0] m_addr,
   output logic [31:0]       m_wdata,
   input  logic              m_ready,
   input  logic [31:0]       m_rdata,
   output logic              irq_o
);
   localparam int DATA_W = 32;
   localparam int SR_W   = $clog2(RST_CYCLES + 1);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
      $error("dma_chan_eng: ADDR_W must lie in 8..32");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("dma_chan_eng: CNT_W must lie in 1..32");
   end
   if (IDX_W < 1 || IDX_W > ADDR_W) begin : g_bad_idx_w
      $error("dma_chan_eng: IDX_W must lie in 1..ADDR_W");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("dma_chan_eng: RST_CYCLES must be at least 1");
   end

   logic [1:0]        src_mode_q, dst_mode_q, dtype_q;
   logic [CNT_W-1:0]  n_elem_q, n_frame_q, cur_elem, cur_frame;
   logic [ADDR_W-1:0] src_base_q, dst_base_q, cur_src, cur_dst;
   logic [IDX_W-1:0]  src_eidx_q, dst_eidx_q, src_fidx_q, dst_fidx_q;
   logic              blk_ie_q, blk_stat_q, irq_stat_q, irq_en_q;
   logic [SR_W-1:0]   srst_cnt_q;
   logic              srst_busy, wr, cfg_wr, srst_go, start, busy, xfer_done;

   assign srst_busy = srst_cnt_q != '0;
   assign wr        = cfg_we && !srst_busy;
   assign cfg_wr    = wr && !busy;
   assign srst_go   = wr && (cfg_addr == A_SRREQ) && cfg_wdata[1];
   assign start     = cfg_wr && (cfg_addr == A_CTRL) && cfg_wdata[7];
   assign irq_o     = irq_stat_q && irq_en_q;
   assign m_size    = dtype_q;

   dma_xfer_ctl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .SIGNED_IDX(SIGNED_IDX)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .clr(srst_go), .start(start),
      .dtype(dtype_q), .src_mode(src_mode_q), .dst_mode(dst_mode_q),
      .n_elem(n_elem_q), .n_frame(n_frame_q),
      .src_base(src_base_q), .dst_base(dst_base_q),
      .src_eidx(src_eidx_q), .src_fidx(src_fidx_q),
      .dst_eidx(dst_eidx_q), .dst_fidx(dst_fidx_q),
      .mem_ready(m_ready), .mem_rdata(m_rdata),
      .busy(busy), .done(xfer_done),
      .mem_valid(m_valid), .mem_we(m_write), .mem_addr(m_addr), .mem_wdata(m_wdata),
      .cur_src(cur_src), .cur_dst(cur_dst), .cur_elem(cur_elem), .cur_frame(cur_frame)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_mode_q <= '0; dst_mode_q <= '0; dtype_q <= '0;
         n_elem_q   <= '0; n_frame_q  <= '0;
         src_base_q <= '0; dst_base_q <= '0;
         src_eidx_q <= '0; dst_eidx_q <= '0; src_fidx_q <= '0; dst_fidx_q <= '0;
         blk_ie_q   <= 1'b0; blk_stat_q <= 1'b0; irq_stat_q <= 1'b0; irq_en_q <= 1'b0;
         srst_cnt_q <= '0;
      end else if (srst_go) begin
         src_mode_q <= '0; dst_mode_q <= '0; dtype_q <= '0;
         n_elem_q   <= '0; n_frame_q  <= '0;
         src_base_q <= '0; dst_base_q <= '0;
         src_eidx_q <= '0; dst_eidx_q <= '0; src_fidx_q <= '0; dst_fidx_q <= '0;
         blk_ie_q   <= 1'b0; blk_stat_q <= 1'b0; irq_stat_q <= 1'b0; irq_en_q <= 1'b0;
         srst_cnt_q <= SR_W'(RST_CYCLES);
      end else begin
         if (srst_busy) srst_cnt_q <= srst_cnt_q - SR_W'(1);
         if (cfg_wr) begin
            unique case (cfg_addr)
               A_CTRL: begin
                  src_mode_q <= cfg_wdata[13:12];
                  dst_mode_q <= cfg_wdata[15:14];
               end
               A_NELEM: n_elem_q   <= cfg_wdata[CNT_W-1:0];
               A_NFRM:  n_frame_q  <= cfg_wdata[CNT_W-1:0];
               A_SBASE: src_base_q <= cfg_wdata[ADDR_W-1:0];
               A_DBASE: dst_base_q <= cfg_wdata[ADDR_W-1:0];
               A_DTYPE: dtype_q    <= (cfg_wdata[1:0] == 2'd3) ? 2'd2 : cfg_wdata[1:0];
               A_SEIDX: src_eidx_q <= cfg_wdata[IDX_W-1:0];
               A_DEIDX: dst_eidx_q <= cfg_wdata[IDX_W-1:0];
               A_SFIDX: src_fidx_q <= cfg_wdata[IDX_W-1:0];
               A_DFIDX: dst_fidx_q <= cfg_wdata[IDX_W-1:0];
               A_BIE:   blk_ie_q   <= cfg_wdata[5];
               default: ;
            endcase
         end
         if (xfer_done) blk_stat_q <= 1'b1;
         else if (wr && cfg_addr == A_BSTAT && cfg_wdata[5]) blk_stat_q <= 1'b0;
         if (xfer_done && blk_ie_q) irq_stat_q <= 1'b1;
         else if (wr && cfg_addr == A_ISTAT && cfg_wdata[0]) irq_stat_q <= 1'b0;
         if (wr && cfg_addr == A_IEN) irq_en_q <= cfg_wdata[0];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      unique case (cfg_addr)
         A_CTRL:  cfg_rdata = {16'd0, dst_mode_q, src_mode_q, 4'd0, busy, 7'd0};
         A_NELEM: cfg_rdata = 32'(n_elem_q);
         A_NFRM:  cfg_rdata = 32'(n_frame_q);
         A_SBASE: cfg_rdata = 32'(src_base_q);
         A_DBASE: cfg_rdata = 32'(dst_base_q);
         A_DTYPE: cfg_rdata = 32'(dtype_q);
         A_SEIDX: cfg_rdata = 32'(src_eidx_q);
         A_DEIDX: cfg_rdata = 32'(dst_eidx_q);
         A_SFIDX: cfg_rdata = 32'(src_fidx_q);
         A_DFIDX: cfg_rdata = 32'(dst_fidx_q);
         A_BIE:   cfg_rdata = {26'd0, blk_ie_q, 5'd0};
         A_BSTAT: cfg_rdata = {26'd0, blk_stat_q, 5'd0};
         A_CSRC:  cfg_rdata = 32'(cur_src);
         A_CDST:  cfg_rdata = 32'(cur_dst);
         A_CELEM: cfg_rdata = 32'(cur_elem);
         A_CFRM:  cfg_rdata = 32'(cur_frame);
         A_ISTAT: cfg_rdata = {31'd0, irq_stat_q};
         A_IEN:   cfg_rdata = {31'd0, irq_en_q};
         A_SRSTS: cfg_rdata = {31'd0, !srst_busy};
         default: cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dma_chan_eng_chk.sv
module dma_chan_eng_chk #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m_valid,
   input logic              m_write,
   input logic              m_ready,
   input logic [ADDR_W-1:0] m_addr,
   input logic              srst_busy,
   input logic              srst_go,
   input logic              start,
   input logic              xfer_done,
   input logic              blk_stat_q,
   input logic [1:0]        src_mode_q,
   input logic [ADDR_W-1:0] cur_src,
   input logic [CNT_W-1:0]  n_elem_q,
   input logic [CNT_W-1:0]  n_frame_q
);
   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready && !srst_go) |=> (m_valid && $stable(m_addr) && $stable(m_write)));

   // R12
   srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst_busy |-> !m_valid);

   // R10
   blk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> blk_stat_q);

   // R3
   const_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_write && m_ready && !srst_go && src_mode_q != 2'd1) |=> $stable(cur_src));

   // R8
   zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (n_elem_q == '0 || n_frame_q == '0)) |=> !m_valid);
endmodule

bind dma_chan_eng dma_chan_eng_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_write(m_write), .m_ready(m_ready),
   .m_addr(m_addr), .srst_busy(srst_busy), .srst_go(srst_go), .start(start),
   .xfer_done(xfer_done), .blk_stat_q(blk_stat_q), .src_mode_q(src_mode_q),
   .cur_src(cur_src), .n_elem_q(n_elem_q), .n_frame_q(n_frame_q)
);

// File: tb/dma_chan_eng_tb.sv
`timescale 1ns/1ps
module dma_chan_eng_tb;
   localparam int AW = 32;
   localparam int RC = 8;
   localparam int SRCB = 16;
   localparam int DSTB = 128;
   localparam logic [4:0] W_CTRL = 0, W_NE = 1, W_NF = 2, W_SB = 3, W_DB = 4, W_DT = 5,
      W_SEI = 6, W_DEI = 7, W_SFI = 8, W_DFI = 9, W_BIE = 10, W_BST = 11, W_CS = 12,
      W_CD = 13, W_CE = 14, W_CF = 15, W_IST = 16, W_IEN = 17, W_SRQ = 18, W_SRS = 19;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [4:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;
   logic m_valid, m_write, m_ready, irq_o;
   logic [1:0] m_size;
   logic [AW-1:0] m_addr;
   logic [31:0] m_wdata, m_rdata;

   logic [7:0] mem [256];
   logic [7:0] expm [256];
   int checks = 0, failures = 0, rd_n = 0, wr_n = 0, scnt = 0;
   bit stall_on = 0, fin = 0;
   logic [1:0] want_size = '0;
   bit size_bad = 0;

   always #2 clk = ~clk;

   dma_chan_eng #(.ADDR_W(AW), .RST_CYCLES(RC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .m_valid(m_valid), .m_write(m_write), .m_size(m_size),
      .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata), .irq_o(irq_o)
   );

   assign m_ready = !stall_on || (scnt % 3 != 0);

   always_comb begin
      m_rdata = '0;
      for (int b = 0; b < 4; b++)
         if (b < (1 << m_size)) m_rdata[8*b +: 8] = mem[(m_addr + b) & 255];
   end

   always @(posedge clk) begin
      scnt <= scnt + 1;
      if (m_valid && m_ready) begin
         if (m_size != want_size) size_bad = 1;
         if (m_write) begin
            wr_n = wr_n + 1;
            for (int b = 0; b < (1 << m_size); b++) mem[(m_addr + b) & 255] = m_wdata[8*b +: 8];
         end else rd_n = rd_n + 1;
      end
   end

   function automatic logic [7:0] init_b(int a);
      return 8'(((a & 255) * 37) + 11);
   endfunction

   task automatic chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      cfg_addr = a; #1; d = cfg_rdata;
   endtask

   task automatic run(int dt, int sm, int dm, int ne, int nf, int ei, int fi,
                      bit stall, bit ie, bit ien, bit poke);
      int es, n, cyc, sa, da, dei, dfi, bad, fs, fd;
      logic [31:0] v;
      es = 1 << (dt > 2 ? 2 : dt); n = ne * nf; dei = 3 - ei; dfi = 3 - fi;
      for (int i = 0; i < 256; i++) begin mem[i] = init_b(i); expm[i] = init_b(i); end
      want_size = 2'(dt > 2 ? 2 : dt); size_bad = 0; stall_on = stall;
      wr(W_NE, ne); wr(W_NF, nf); wr(W_SB, SRCB); wr(W_DB, DSTB); wr(W_DT, dt);
      wr(W_SEI, ei); wr(W_DEI, dei); wr(W_SFI, fi); wr(W_DFI, dfi);
      wr(W_BIE, ie ? 32 : 0); wr(W_IEN, {31'd0, ien});
      rd_n = 0; wr_n = 0;
      wr(W_CTRL, 32'((dm << 14) | (sm << 12) | (1 << 7)));
      if (poke) begin
         // R13: setup write during the run must not land
         wr(W_SB, 32'h44); rd(W_SB, v);
         chk(v == SRCB, "R13 base write while running", v, SRCB);
      end
      cyc = 0; rd(W_CTRL, v);
      while (v[7] && cyc < 2000) begin cyc++; @(negedge clk); rd(W_CTRL, v); end
      stall_on = 0;
      for (int f = 0; f < nf; f++)
         for (int e = 0; e < ne; e++) begin
            sa = SRCB + (sm == 1 ? es * (f * (ne * ei + fi - 1) + e * ei) : 0);
            da = DSTB + (dm == 1 ? es * (f * (ne * dei + dfi - 1) + e * dei) : 0);
            for (int b = 0; b < es; b++) expm[(da + b) & 255] = init_b(sa + b);
         end
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) bad++;
      chk(bad == 0, "R4 R2 destination bytes", bad, 0);
      chk(!size_bad, "R2 beat size", m_size, want_size);
      chk(rd_n == n && wr_n == n, "R5 beat counts", rd_n * 1000 + wr_n, n * 1000 + n);
      if (!stall && !poke) chk(cyc == 2 * n, "R5 R7 busy cycles", cyc, 2 * n);
      chk(v[7] == 1'b0, "R7 enable self-clear", v[7], 0);
      if (n == 0) chk(cyc == 0 && rd_n == 0, "R8 empty block", cyc, 0);
      fs = SRCB + ((sm == 1 && n > 0) ? es * nf * (ne * ei + fi - 1) : 0);
      fd = DSTB + ((dm == 1 && n > 0) ? es * nf * (ne * dei + dfi - 1) : 0);
      rd(W_CS, v); chk(v == fs, "R9 R4 current source", v, fs);
      rd(W_CD, v); chk(v == fd, "R9 R4 current destination", v, fd);
      rd(W_CE, v); chk(v == 0, "R9 element position", v, 0);
      rd(W_CF, v); chk(v == (n > 0 ? nf : 0), "R9 frame position", v, n > 0 ? nf : 0);
      rd(W_BST, v); chk(v[5] == 1'b1, "R10 block status set", v, 32);
      rd(W_IST, v); chk(v[0] == ie, "R11 interrupt status", v[0], ie);
      chk(irq_o == (ie && ien), "R11 irq output", irq_o, ie && ien);
      wr(W_BST, 0); rd(W_BST, v); chk(v[5] == 1'b1, "R10 write 0 keeps status", v, 32);
      wr(W_BST, 32); rd(W_BST, v); chk(v[5] == 1'b0, "R10 write 1 clears", v, 0);
      wr(W_IEN, 1); chk(irq_o == ie, "R11 irq after enable", irq_o, ie);
      wr(W_IST, 1); chk(irq_o == 0, "R11 irq after clear", irq_o, 0);
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1
      rd(W_SRS, v); chk(v[0] == 1'b1, "R1 reset-done bit", v, 1);
      rd(W_CTRL, v); chk(v == 0, "R1 control", v, 0);
      rd(W_SB, v); chk(v == 0, "R1 source base", v, 0);
      rd(W_NE, v); chk(v == 0, "R1 element count", v, 0);
      chk(irq_o == 0, "R1 irq", irq_o, 0);

      for (int dt = 0; dt < 3; dt++)
         for (int sm = 0; sm < 2; sm++)
            for (int dm = 0; dm < 2; dm++)
               for (int ne = 0; ne < 4; ne++)
                  for (int nf = 0; nf < 3; nf++)
                     for (int ei = 1; ei < 3; ei++)
                        for (int fi = 1; fi < 3; fi++)
                           run(dt, sm, dm, ne, nf, ei, fi, 0, 1, 1, 0);

      // R3: mode codes 2 and 3 act as constant
      run(1, 2, 3, 3, 2, 1, 2, 0, 1, 1, 0);
      // R2: size code 3 behaves as 4 bytes
      run(3, 1, 1, 2, 2, 1, 1, 0, 1, 1, 0);
      // R6: stalled memory
      for (int dt = 0; dt < 3; dt++) run(dt, 1, 1, 3, 2, 2, 1, 1, 1, 1, 0);
      // R11: interrupt masked, and block interrupt disabled
      run(2, 1, 1, 2, 2, 1, 1, 0, 1, 0, 0);
      run(2, 1, 0, 2, 1, 1, 1, 0, 0, 1, 0);
      // R13
      run(2, 1, 1, 3, 3, 1, 1, 1, 1, 1, 1);

      // R12: soft reset mid-transfer
      wr(W_NE, 3); wr(W_NF, 3); wr(W_SB, SRCB); wr(W_IEN, 1); wr(W_BIE, 32);
      stall_on = 1;
      wr(W_CTRL, 32'h0000_5080);
      wr(W_SRQ, 2);
      chk(m_valid == 0, "R12 transfer aborted", m_valid, 0);
      rd(W_SRS, v); chk(v[0] == 0, "R12 reset in progress", v, 0);
      wr(W_NE, 5);
      repeat (RC - 2) @(negedge clk);
      rd(W_SRS, v); chk(v[0] == 1'b1, "R12 reset done", v, 1);
      rd(W_NE, v); chk(v == 0, "R12 write ignored during reset", v, 0);
      rd(W_SB, v); chk(v == 0, "R12 base cleared", v, 0);
      rd(W_IEN, v); chk(v == 0, "R12 enable cleared", v, 0);
      rd(W_CTRL, v); chk(v == 0, "R12 control cleared", v, 0);
      stall_on = 0;

      fin = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 190000);
      if (!fin) begin
         failures++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule